// File: doc/BRIEF.md
# Fiber Line Frequency Decoder Receiver

This receiver turns a frequency-coded optical line back into a UART receive level. Every line symbol begins with a rising edge. A 0 symbol is one full cycle of the low line frequency. A 1 symbol is two cycles at twice that frequency. The block runs on the sampling clock. It cleans the raw input with a small agreement filter and times each gap between consecutive filtered rising edges. It classifies each gap as long, short, ambiguous or overlong, and then drives a single idle-high output that connects straight to a UART RX pin. The transmitter repeats symbols to make up each UART bit, so a run of decoded symbols forms one UART bit of the correct length. No rate conversion is needed.

The nominal symbol length, in sampling clocks, is a run-time input. All decision limits are derived from it. A three-state machine tracks symbol alignment:

- `ST_WAIT`: not aligned.
- `ST_SYNC`: at a symbol boundary.
- `ST_HALF`: the first short gap of a 1 symbol has been seen.

Transitions:

- align: `ST_WAIT` to `ST_SYNC` on any rising edge. Nothing is decoded.
- first-half: `ST_SYNC` to `ST_HALF` on a short gap.
- stay-sync: `ST_SYNC` to `ST_SYNC` on a long, guard or overlong gap.
- complete: `ST_HALF` to `ST_SYNC` on a rising edge. A 1 is emitted only if the gap is short.
- timeout: `ST_HALF` to `ST_WAIT` when no second short gap can still arrive.

Top module: `fiber_rx_decoder`

## Requirements
- R1: After reset `rx_o` is 1 and the machine is in `ST_WAIT`. The first filtered rising edge after reset only aligns the decoder and never changes `rx_o`.
- R2: The input passes through two sampling flops. The filtered level changes only when both flops hold the same value, so a pulse one sample wide never creates a rising edge.
- R3: A gap of at least P - floor(P/6) clocks, where P is `period_i`, seen in `ST_SYNC` drives `rx_o` to 0. For P = 40 this means 34 or more.
- R4: A gap of at most floor(2P/3) clocks, immediately followed by a second such gap, drives `rx_o` to 1 exactly once, at the end of the second gap. The first gap alone leaves `rx_o` unchanged. For P = 40 this means 26 or less.
- R5: A gap strictly between the short and long limits is a guard-band gap. It is never decoded, and `rx_o` keeps its value. For P = 40 this covers 27 to 33.
- R6: The gap counter stops at P + floor(P/2) + 3 (63 for P = 40) and never wraps. A rising edge that ends a gap with the counter at that limit leaves `rx_o` unchanged, as does an idle line.
- R7: In `ST_HALF`, once the running gap exceeds the short limit with no edge, the lone short gap is dropped. The decoder returns to `ST_WAIT`, and the next rising edge only realigns it.
- R8: `period_i` is sampled continuously, so decoding works for any symbol length set at run time (for example 24 and 80).
- R9: `rx_o` changes only in the clock after a filtered rising edge is detected, which is four clocks after the input edge reaches `optic_in`. It is steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| optic_in | input | 1 | Raw level from the optical receiver |
| period_i | input | PER_W (7) | Nominal symbol length in clocks |
| rx_o | output | 1 | Recovered UART receive level, idle high |

## Verification
On every cycle the assertions check four things:

- `rx_o` moves only just after a detected edge.
- A rise of `rx_o` comes only out of `ST_HALF`, and a fall only out of `ST_SYNC`.
- The gap counter either clears or steps by one and never wraps.
- An expired half symbol always falls back to `ST_WAIT`.

Several behaviours can only be shown by the directed scenarios:

- The exact limits that separate long, guard and short gaps.
- Rejection of single-sample glitches.
- Holding the output across a saturated gap.
- Realignment after a lone short gap.
- Correct decoding at other run-time symbol lengths.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

    // Alignment state of the symbol decoder
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // not aligned to a symbol boundary
        ST_SYNC = 2'd1,   // last edge was a symbol boundary
        ST_HALF = 2'd2    // first short gap of a 1 symbol seen
    } dec_state_t;

    // Classification of one completed edge-to-edge gap
    typedef enum logic [1:0] {
        IV_LONG  = 2'd0,
        IV_SHORT = 2'd1,
        IV_GUARD = 2'd2,
        IV_SAT   = 2'd3
    } iv_class_t;

endpackage

// File: rtl/fdec_glitch_filter.sv
module fdec_glitch_filter #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic filt_o
);

    logic [DEPTH-1:0] shift_q;
    logic             all_high;
    logic             all_low;

    // Sampling chain: stage 0 takes the raw input
    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shift_q <= '0;
                else        shift_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shift_q <= '0;
                else        shift_q <= {shift_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign all_high = &shift_q;
    assign all_low  = ~|shift_q;

    // Filtered level moves only when every stage agrees
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        filt_o <= 1'b0;
        else if (all_high) filt_o <= 1'b1;
        else if (all_low)  filt_o <= 1'b0;
    end

endmodule

// File: rtl/fdec_interval_meter.sv
module fdec_interval_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filt_i,
    input  logic [CNT_W-1:0] sat_lim_i,
    output logic             rise_o,
    output logic [CNT_W-1:0] iv_len_o,
    output logic             iv_sat_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= filt_i;
    end

    assign rise_o = filt_i & ~prev_q;

    // Clocks since the last rising edge; starts saturated so the
    // first edge after reset carries no usable gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '1;
        else if (rise_o)            cnt_q <= '0;
        else if (cnt_q < sat_lim_i) cnt_q <= cnt_q + 1'b1;
    end

    // Gap length as seen on the edge cycle (edge-to-edge distance)
    assign iv_len_o = cnt_q + 1'b1;
    assign iv_sat_o = (cnt_q >= sat_lim_i);
    assign cnt_o    = cnt_q;

endmodule

// File: rtl/fdec_classifier.sv
module fdec_classifier #(
    parameter int PER_W = 7,
    parameter int CNT_W = 8
) (
    input  logic [PER_W-1:0]     period_i,
    input  logic [CNT_W-1:0]     iv_len_i,
    input  logic                 iv_sat_i,
    input  logic [CNT_W-1:0]     cnt_i,
    output fdec_pkg::iv_class_t  cls_o,
    output logic                 half_late_o,
    output logic [CNT_W-1:0]     short_max_o,
    output logic [CNT_W-1:0]     sat_lim_o
);
    import fdec_pkg::*;

    localparam logic [CNT_W-1:0] K_TWO   = CNT_W'(2);
    localparam logic [CNT_W-1:0] K_THREE = CNT_W'(3);
    localparam logic [CNT_W-1:0] K_SIX   = CNT_W'(6);

    logic [CNT_W-1:0] per_x;
    logic [CNT_W-1:0] long_min;
    logic [CNT_W-1:0] short_max;
    logic [CNT_W-1:0] sat_lim;

    assign per_x     = {{(CNT_W-PER_W){1'b0}}, period_i};
    // about 5/6 of the symbol: shortest gap taken as a 0
    assign long_min  = per_x - (per_x / K_SIX);
    // about 2/3 of the symbol: longest gap taken as a half of a 1
    assign short_max = (per_x * K_TWO) / K_THREE;
    // counter ceiling, comfortably past one full symbol
    assign sat_lim   = per_x + (per_x >> 1) + K_THREE;

    always_comb begin
        if (iv_sat_i)                  cls_o = IV_SAT;
        else if (iv_len_i >= long_min) cls_o = IV_LONG;
        else if (iv_len_i <= short_max) cls_o = IV_SHORT;
        else                           cls_o = IV_GUARD;
    end

    // A gap now running this long can no longer end as a short one
    assign half_late_o = (cnt_i >= short_max);
    assign short_max_o = short_max;
    assign sat_lim_o   = sat_lim;

endmodule

// File: rtl/fiber_rx_decoder.sv
module fiber_rx_decoder #(
    parameter int PER_W = 7,
    parameter int FILT_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             optic_in,
    input  logic [PER_W-1:0] period_i,
    output logic             rx_o
);
    import fdec_pkg::*;

    // Counter wide enough for the largest saturation limit
    localparam int SAT_MAX = ((2 ** PER_W) - 1) * 3 / 2 + 5;
    localparam int CNT_W   = $clog2(SAT_MAX);

    logic             filt_w;
    logic             rise_w;
    logic [CNT_W-1:0] iv_len_w;
    logic             iv_sat_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] short_max_w;
    logic [CNT_W-1:0] sat_lim_w;
    logic             half_late_w;
    iv_class_t        cls_w;

    dec_state_t       state_q;
    dec_state_t       state_d;

    fdec_glitch_filter #(
        .DEPTH (FILT_DEPTH)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (optic_in),
        .filt_o (filt_w)
    );

    fdec_interval_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_i    (filt_w),
        .sat_lim_i (sat_lim_w),
        .rise_o    (rise_w),
        .iv_len_o  (iv_len_w),
        .iv_sat_o  (iv_sat_w),
        .cnt_o     (cnt_w)
    );

    fdec_classifier #(
        .PER_W (PER_W),
        .CNT_W (CNT_W)
    ) u_class (
        .period_i    (period_i),
        .iv_len_i    (iv_len_w),
        .iv_sat_i    (iv_sat_w),
        .cnt_i       (cnt_w),
        .cls_o       (cls_w),
        .half_late_o (half_late_w),
        .short_max_o (short_max_w),
        .sat_lim_o   (sat_lim_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (rise_w) state_d = ST_SYNC;                  // align
            end
            ST_SYNC: begin
                if (rise_w && cls_w == IV_SHORT) state_d = ST_HALF; // first-half
            end
            ST_HALF: begin
                if (rise_w)           state_d = ST_SYNC;        // complete
                else if (half_late_w) state_d = ST_WAIT;        // timeout
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // Output register: decoded level, idle high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_o <= 1'b1;
        end else if (rise_w) begin
            if (state_q == ST_SYNC && cls_w == IV_LONG)
                rx_o <= 1'b0;
            else if (state_q == ST_HALF && cls_w == IV_SHORT)
                rx_o <= 1'b1;
        end
    end

endmodule

// File: rtl/fdec_checker.sv
module fdec_checker #(
    parameter int CNT_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_o,
    input logic                 rise,
    input logic [CNT_W-1:0]     cnt,
    input logic [CNT_W-1:0]     short_max,
    input fdec_pkg::dec_state_t state
);
    import fdec_pkg::*;

    // R1: output forced high while reset is held
    a_r1_idle_high: assert property (@(posedge clk)
        !rst_n |=> rx_o);

    // R9: output moves only right after a detected edge
    a_r9_rx_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_o) |-> $past(rise));

    // R4: a 1 is emitted only when completing a half symbol
    a_r4_one_from_half: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_o) |-> $past(state == ST_HALF));

    // R3: a 0 is emitted only from a symbol boundary
    a_r3_zero_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_o) |-> $past(state == ST_SYNC));

    // R6: counter clears or steps by one, never wraps
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

    // R7: an expired half symbol drops back to alignment
    a_r7_half_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALF && !rise && cnt >= short_max) |=> (state == ST_WAIT));

endmodule

bind fiber_rx_decoder fdec_checker #(.CNT_W(CNT_W)) u_fdec_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_o      (rx_o),
    .rise      (rise_w),
    .cnt       (cnt_w),
    .short_max (short_max_w),
    .state     (state_q)
);

// File: tb/fiber_rx_decoder_bench.sv
module fiber_rx_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       optic = 1'b0;
    logic [6:0] period = 7'd40;
    logic       rx;
    int         P = 40;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    fiber_rx_decoder u_fiber_rx_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .optic_in (optic),
        .period_i (period),
        .rx_o     (rx)
    );

    task automatic chk(input logic exp, input string tag);
        n_chk++;
        if (rx !== exp) begin
            n_fail++;
            $display("FAIL %s: rx=%b expected %b", tag, rx, exp);
        end
    endtask

    task automatic set_period(input int p);
        P = p;
        period = 7'(p);
    endtask

    // One line symbol; checks rx (result of the previous symbol) early
    // and again at the last clock before the next edge
    task automatic sym(input logic b, input logic exp, input bit chk_en,
                       input string tag, input int g1 = -1, input int g2 = -1);
        int q = P / 4;
        for (int i = 0; i < P; i++) begin
            logic lv;
            if (b) lv = (i < q) || (i >= 2*q && i < 3*q);
            else   lv = (i < P/2);
            if (i == g1 || i == g2) lv = 1'b1;
            optic = lv;
            @(negedge clk);
            if (chk_en && i == 4)     chk(exp, tag);
            if (chk_en && i == P - 1) chk(exp, {"R9 steady between edges / ", tag});
        end
    endtask

    task automatic cyc(input int hi, input int lo, input logic exp,
                       input bit chk_en, input string tag);
        for (int i = 0; i < hi + lo; i++) begin
            optic = (i < hi);
            @(negedge clk);
            if (chk_en && i == 4) chk(exp, tag);
        end
    endtask

    task automatic low(input int n);
        optic = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(1'b1, "R1 idle high after reset");
        sym(1'b0, 1'b1, 1, "R1 first edge only aligns");
    endtask

    task automatic t_zeros;
        sym(1'b0, 1'b0, 1, "R3 long gap decodes 0");
        sym(1'b0, 1'b0, 1, "R3 repeated 0");
    endtask

    task automatic t_ones;
        sym(1'b1, 1'b0, 1, "R4 setup");
        sym(1'b1, 1'b1, 1, "R4 two short gaps give 1");
        sym(1'b0, 1'b1, 1, "R4 second 1");
        sym(1'b0, 1'b0, 1, "R4 one bit per symbol then 0");
    endtask

    task automatic t_glitch;
        sym(1'b0, 1'b0, 1, "R2 setup", 22, 31);
        sym(1'b0, 1'b0, 1, "R2 single-sample pulses ignored");
    endtask

    task automatic t_guard;
        sym(1'b1, 1'b0, 1, "R5 setup");
        cyc(15, 15, 1'b1, 1, "R4 1 completed");
        sym(1'b0, 1'b1, 1, "R5 30-clock gap holds");
        sym(1'b0, 1'b0, 1, "R3 decoding after guard");
        sym(1'b1, 1'b0, 1, "R4 setup");
        cyc(17, 16, 1'b1, 1, "R4 short pair gives 1");
        cyc(17, 17, 1'b1, 1, "R5 33-clock gap holds");
        sym(1'b0, 1'b0, 1, "R3 34-clock gap gives 0");
        cyc(13, 13, 1'b0, 1, "R3 setup");
        cyc(13, 13, 1'b0, 1, "R4 first short half holds");
        sym(1'b0, 1'b1, 1, "R4 26-clock halves give 1");
        cyc(14, 13, 1'b0, 1, "R3 setup");
        cyc(14, 13, 1'b0, 1, "R5 27-clock gap holds");
        sym(1'b0, 1'b0, 1, "R5 27-clock pair gives no 1");
    endtask

    task automatic t_sat;
        sym(1'b1, 1'b0, 1, "R6 setup");
        sym(1'b0, 1'b1, 1, "R6 setup 1");
        low(300);
        chk(1'b1, "R6 idle line holds");
        sym(1'b0, 1'b1, 1, "R6 saturated gap holds");
        sym(1'b0, 1'b0, 1, "R6 decoding resumes");
    endtask

    task automatic t_lone;
        cyc(10, 10, 1'b0, 1, "R7 setup");
        cyc(30, 30, 1'b0, 1, "R7 lone short from 0 holds");
        sym(1'b0, 1'b0, 1, "R7 realign edge not decoded");
        sym(1'b1, 1'b0, 1, "R7 setup");
        cyc(10, 10, 1'b1, 1, "R7 setup 1");
        cyc(30, 30, 1'b1, 1, "R7 lone short from 1 holds");
        sym(1'b0, 1'b1, 1, "R7 realign edge not decoded");
        sym(1'b0, 1'b0, 1, "R7 decoding resumes after realign");
    endtask

    task automatic t_period;
        set_period(24);
        low(200);
        sym(1'b1, 1'b0, 1, "R8 P=24 saturated edge holds");
        sym(1'b1, 1'b1, 1, "R8 P=24 one");
        sym(1'b0, 1'b1, 1, "R8 P=24 one again");
        sym(1'b1, 1'b0, 1, "R8 P=24 zero");
        sym(1'b0, 1'b1, 1, "R8 P=24 one after zero");
        set_period(80);
        low(200);
        sym(1'b0, 1'b1, 1, "R8 P=80 saturated edge holds");
        sym(1'b1, 1'b0, 1, "R8 P=80 zero");
        sym(1'b0, 1'b1, 1, "R8 P=80 one");
        sym(1'b0, 1'b0, 1, "R8 P=80 zero again");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run incomplete (actual hung, expected done)");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zeros();
        t_ones();
        t_glitch();
        t_guard();
        t_sat();
        t_lone();
        t_period();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule